// File: doc/BRIEF.md
# Wait/Stop Sequencer with Wake-Source Priority

This block sequences the two low-power states of a processor core and decides which event ends them. A decoded wait strobe parks the core with its ready line held low while the internal clock keeps running. A decoded stop strobe gates the internal clock off entirely. Four active-low event lines can end a wait. In falling order of precedence they are the reset line, abort, the non-maskable interrupt and the maskable interrupt. The interrupt mask flag from the status register is also an input.

When a wait ends, the block reports the chosen source as a two-bit vector-select code with a one-cycle valid pulse. A maskable interrupt that arrives while the mask flag is set gives a different result. No vector is taken; a one-cycle pulse instead tells the core to carry on with the instruction after the wait. An abort during a wait is reported but does not restart the core. The core stays parked, and the next wake is flagged so that the handler returns to the wait instruction. The stop state ignores every event except a falling edge on the reset line.

Vector fetch, clock generation and the instruction pipeline are outside this block. The block has its own flop reset (`rst_ni`), which is kept separate from the processor's reset event line.

Top module: `wait_stop_arbiter`

## Requirements
- R1: A `wai_exec` pulse in the running state drives `rdy` low from the next cycle, and `core_clk_en` stays high while waiting. If `stp_exec` is also high in that cycle, the stop state wins.
- R2: While waiting, a low `rst_line_n` ends the wait. In the next cycle `rdy` is high, `vec_valid` pulses and `vec_sel` is 00.
- R3: When several wake sources are present in the same cycle, the source served is chosen in this order: reset line (00), abort (01), NMI (10), IRQ (11).
- R4: The first low `abort_n` in a wait pulses `vec_valid` with `vec_sel` 01 and keeps `rdy` low. While the abort is held, it raises no further vector in that wait.
- R5: Every wake that follows an abort in the same wait, other than the reset line, pulses `ret_to_wai` together with its `vec_valid` or `resume_next` pulse. Otherwise `ret_to_wai` stays low.
- R6: The NMI is detected on a falling edge of `nmi_n`, and the edge is remembered even when it arrives in the running state. A pending NMI wakes with `vec_sel` 10. An `nmi_n` held low without a new edge does not wake a later wait.
- R7: While waiting, a low `irq_n` with `irq_mask` clear wakes with `vec_valid` and `vec_sel` 11.
- R8: While waiting, a low `irq_n` with `irq_mask` set ends the wait with a one-cycle `resume_next` pulse and no `vec_valid`.
- R9: A `stp_exec` pulse drives `core_clk_en` low from the next cycle, and `rdy` stays high. In the stop state the abort, NMI and IRQ lines have no effect. A reset line that was already low on entry also has no effect.
- R10: The stop state ends only on a falling edge of `rst_line_n`. In the next cycle `core_clk_en` is high and `vec_valid` pulses with `vec_sel` 00.
- R11: After `rst_ni` the block is running: `rdy`=1, `core_clk_en`=1, and all pulses are 0 with `vec_sel`=00. `vec_valid`, `resume_next` and `ret_to_wai` last one cycle. `vec_sel` holds its last code between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_ni | input | 1 | Asynchronous active-low flop reset |
| rst_line_n | input | 1 | Processor reset event line, active low |
| abort_n | input | 1 | Abort event line, active low |
| nmi_n | input | 1 | Non-maskable interrupt line, falling-edge sensitive |
| irq_n | input | 1 | Maskable interrupt line, level sensitive, active low |
| irq_mask | input | 1 | Interrupt mask flag from the status register |
| wai_exec | input | 1 | One-cycle strobe: wait instruction executed |
| stp_exec | input | 1 | One-cycle strobe: stop instruction executed |
| rdy | output | 1 | Ready drive, low while waiting |
| core_clk_en | output | 1 | Internal clock enable, low while stopped |
| resume_next | output | 1 | Pulse: continue after the wait without a handler |
| vec_valid | output | 1 | Pulse: a handler vector is selected |
| vec_sel | output | 2 | Vector code: 00 reset, 01 abort, 10 NMI, 11 IRQ |
| ret_to_wai | output | 1 | Pulse with a wake: handler must return to the wait |

## Verification
The bench drives all four sources together in one cycle. A broken priority chain would report the wrong code there, for example an NMI when reset was present. Aborts are held low across many cycles, so a design that re-arms the abort would emit repeated 01 vectors. A design that forgets the abort would fail to flag the later wake. The NMI is tested in three ways: with its edge latched in the running state, held low across a second wait, and arriving together with an abort. A level-sensitive or forgetful NMI would then wake when it should not, or stay asleep when it should wake. In the stop state the reset line is low on entry and other events are applied. A level-triggered exit would leave the stop state early, and an ungated event line would restart the clock.

// File: rtl/wait_stop_pkg.sv
package wait_stop_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_STOP = 2'd2
    } ws_state_e;

    localparam int unsigned SRC_NUM = 4;
    localparam int unsigned SRC_W   = $clog2(SRC_NUM);

    typedef logic [SRC_W-1:0] vec_code_t;

    // request index equals vector code; lower index has priority
    localparam vec_code_t VEC_RESET = 2'd0;
    localparam vec_code_t VEC_ABORT = 2'd1;
    localparam vec_code_t VEC_NMI   = 2'd2;
    localparam vec_code_t VEC_IRQ   = 2'd3;

    typedef struct packed {
        ws_state_e state;
        logic      abort_seen;
        logic      nmi_pend;
        logic      vec_valid;
        vec_code_t vec_sel;
        logic      resume;
        logic      ret_wai;
    } ws_regs_t;

endpackage

// File: rtl/ws_fall_det.sv
module ws_fall_det #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_n,
    output logic [W-1:0] fell
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_n;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '1;
        else         prev_q <= prev_d;
    end

    assign fell = prev_q & ~lvl_n;

endmodule

// File: rtl/ws_prio_pick.sv
module ws_prio_pick #(
    parameter int unsigned N  = 4,
    localparam int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [CW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = CW'(i);
        end
    end

    // R3: the chosen index is requested and nothing below it is
    always_comb begin
        if (any) begin
            pick_hit_chk: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
        end
    end

endmodule

// File: rtl/ws_seq_fsm.sv
module ws_seq_fsm
    import wait_stop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              rst_line_n,
    input  logic              abort_n,
    input  logic              irq_n,
    input  logic              irq_mask,
    input  logic              wai_exec,
    input  logic              stp_exec,
    input  logic              rst_fell,
    input  logic              nmi_fell,
    input  logic              pick_any,
    input  vec_code_t         pick_idx,
    output logic [SRC_NUM-1:0] req,
    output logic              rdy,
    output logic              core_clk_en,
    output logic              resume_next,
    output logic              vec_valid,
    output vec_code_t         vec_sel,
    output logic              ret_to_wai
);
    ws_regs_t r_d, r_q;
    logic     nmi_req;

    always_comb begin
        nmi_req            = r_q.nmi_pend | nmi_fell;
        req                = '0;
        req[VEC_RESET]     = ~rst_line_n;
        req[VEC_ABORT]     = ~abort_n & ~r_q.abort_seen;
        req[VEC_NMI]       = nmi_req;
        req[VEC_IRQ]       = ~irq_n;

        r_d           = r_q;
        r_d.vec_valid = 1'b0;
        r_d.resume    = 1'b0;
        r_d.ret_wai   = 1'b0;

        unique case (r_q.state)
            ST_RUN: begin
                if (nmi_fell) r_d.nmi_pend = 1'b1;
                if (stp_exec) begin
                    r_d.state = ST_STOP;
                end else if (wai_exec) begin
                    r_d.state      = ST_WAIT;
                    r_d.abort_seen = 1'b0;
                end
            end
            ST_WAIT: begin
                if (pick_any) begin
                    unique case (pick_idx)
                        VEC_RESET: begin
                            r_d.state      = ST_RUN;
                            r_d.vec_valid  = 1'b1;
                            r_d.vec_sel    = VEC_RESET;
                            r_d.nmi_pend   = 1'b0;
                            r_d.abort_seen = 1'b0;
                        end
                        VEC_ABORT: begin
                            r_d.vec_valid  = 1'b1;
                            r_d.vec_sel    = VEC_ABORT;
                            r_d.abort_seen = 1'b1;
                            r_d.nmi_pend   = nmi_req;
                        end
                        VEC_NMI: begin
                            r_d.state      = ST_RUN;
                            r_d.vec_valid  = 1'b1;
                            r_d.vec_sel    = VEC_NMI;
                            r_d.nmi_pend   = 1'b0;
                            r_d.ret_wai    = r_q.abort_seen;
                            r_d.abort_seen = 1'b0;
                        end
                        default: begin
                            r_d.state      = ST_RUN;
                            if (irq_mask) begin
                                r_d.resume    = 1'b1;
                            end else begin
                                r_d.vec_valid = 1'b1;
                                r_d.vec_sel   = VEC_IRQ;
                            end
                            r_d.ret_wai    = r_q.abort_seen;
                            r_d.abort_seen = 1'b0;
                        end
                    endcase
                end
            end
            ST_STOP: begin
                if (rst_fell) begin
                    r_d.state      = ST_RUN;
                    r_d.vec_valid  = 1'b1;
                    r_d.vec_sel    = VEC_RESET;
                    r_d.nmi_pend   = 1'b0;
                    r_d.abort_seen = 1'b0;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_RUN, abort_seen: 1'b0, nmi_pend: 1'b0, vec_valid: 1'b0,
                     vec_sel: VEC_RESET, resume: 1'b0, ret_wai: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rdy         = (r_q.state != ST_WAIT);
    assign core_clk_en = (r_q.state != ST_STOP);
    assign resume_next = r_q.resume;
    assign vec_valid   = r_q.vec_valid;
    assign vec_sel     = r_q.vec_sel;
    assign ret_to_wai  = r_q.ret_wai;

    // R1
    wai_enter_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (r_q.state == ST_RUN && wai_exec && !stp_exec) |=> !rdy);

    // R2
    rst_wake_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (r_q.state == ST_WAIT && !rst_line_n) |=> (rdy && vec_valid && vec_sel == VEC_RESET));

    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        !(resume_next && vec_valid));

    // R9
    clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (r_q.state == ST_RUN && stp_exec) |=> (!core_clk_en && rdy));

    // R10
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (r_q.state == ST_STOP && !rst_fell) |=> !core_clk_en);

    // R5
    ret_pair_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        ret_to_wai |-> (resume_next || vec_valid));

    // R4
    abort_stay_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (r_q.state == ST_WAIT && rst_line_n && !abort_n && !r_q.abort_seen)
        |=> (!rdy && vec_valid && vec_sel == VEC_ABORT));

endmodule

// File: rtl/wait_stop_arbiter.sv
module wait_stop_arbiter
    import wait_stop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_ni,
    input  logic       rst_line_n,
    input  logic       abort_n,
    input  logic       nmi_n,
    input  logic       irq_n,
    input  logic       irq_mask,
    input  logic       wai_exec,
    input  logic       stp_exec,
    output logic       rdy,
    output logic       core_clk_en,
    output logic       resume_next,
    output logic       vec_valid,
    output logic [1:0] vec_sel,
    output logic       ret_to_wai
);
    localparam int unsigned EDGE_N = 2;

    logic [EDGE_N-1:0]  fell;
    logic [SRC_NUM-1:0] req;
    logic               pick_any;
    vec_code_t          pick_idx;
    vec_code_t          sel;

    ws_fall_det #(.W(EDGE_N)) u_edges (
        .clk    (clk),
        .rst_ni (rst_ni),
        .lvl_n  ({nmi_n, rst_line_n}),
        .fell   (fell)
    );

    ws_prio_pick #(.N(SRC_NUM)) u_pick (
        .req (req),
        .any (pick_any),
        .idx (pick_idx)
    );

    ws_seq_fsm u_fsm (
        .clk         (clk),
        .rst_ni      (rst_ni),
        .rst_line_n  (rst_line_n),
        .abort_n     (abort_n),
        .irq_n       (irq_n),
        .irq_mask    (irq_mask),
        .wai_exec    (wai_exec),
        .stp_exec    (stp_exec),
        .rst_fell    (fell[0]),
        .nmi_fell    (fell[1]),
        .pick_any    (pick_any),
        .pick_idx    (pick_idx),
        .req         (req),
        .rdy         (rdy),
        .core_clk_en (core_clk_en),
        .resume_next (resume_next),
        .vec_valid   (vec_valid),
        .vec_sel     (sel),
        .ret_to_wai  (ret_to_wai)
    );

    assign vec_sel = sel;

endmodule

// File: tb/wait_stop_arbiter_tb.sv
module wait_stop_arbiter_tb_top;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic rst_line_n = 1'b1, abort_n = 1'b1, nmi_n = 1'b1, irq_n = 1'b1;
    logic irq_mask = 1'b0, wai_exec = 1'b0, stp_exec = 1'b0;
    logic rdy, core_clk_en, resume_next, vec_valid, ret_to_wai;
    logic [1:0] vec_sel;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wait_stop_arbiter dut_i (
        .clk(clk), .rst_ni(rst_ni), .rst_line_n(rst_line_n), .abort_n(abort_n),
        .nmi_n(nmi_n), .irq_n(irq_n), .irq_mask(irq_mask), .wai_exec(wai_exec),
        .stp_exec(stp_exec), .rdy(rdy), .core_clk_en(core_clk_en),
        .resume_next(resume_next), .vec_valid(vec_valid), .vec_sel(vec_sel),
        .ret_to_wai(ret_to_wai)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: 0 running, 1 waiting, 2 stopped
    int m_st, m_ab, m_np, m_pn, m_pr, m_vv, m_vs, m_rs, m_rt;
    bit nf, rf;

    always @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            m_st = 0; m_ab = 0; m_np = 0; m_pn = 1; m_pr = 1;
            m_vv = 0; m_vs = 0; m_rs = 0; m_rt = 0;
        end else begin
            nf = (m_pn == 1) && !nmi_n;
            rf = (m_pr == 1) && !rst_line_n;
            m_pn = nmi_n; m_pr = rst_line_n;
            m_vv = 0; m_rs = 0; m_rt = 0;
            if (m_st == 0) begin
                if (nf) m_np = 1;
                if (stp_exec) m_st = 2;
                else if (wai_exec) begin m_st = 1; m_ab = 0; end
            end else if (m_st == 2) begin
                if (rf) begin m_st = 0; m_vv = 1; m_vs = 0; m_np = 0; m_ab = 0; end
            end else begin
                if (nf) m_np = 1;
                if (!rst_line_n) begin
                    m_st = 0; m_vv = 1; m_vs = 0; m_np = 0; m_ab = 0;
                end else if (!abort_n && m_ab == 0) begin
                    m_vv = 1; m_vs = 1; m_ab = 1;
                end else if (m_np == 1) begin
                    m_st = 0; m_vv = 1; m_vs = 2; m_np = 0; m_rt = m_ab; m_ab = 0;
                end else if (!irq_n) begin
                    m_st = 0;
                    if (irq_mask) m_rs = 1;
                    else begin m_vv = 1; m_vs = 3; end
                    m_rt = m_ab; m_ab = 0;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_ni && !done) begin
            check(rdy == (m_st != 1), "R1 rdy", rdy, m_st != 1);
            check(core_clk_en == (m_st != 2), "R9 core_clk_en", core_clk_en, m_st != 2);
            check(vec_valid == m_vv[0], "R3 vec_valid", vec_valid, m_vv);
            check(vec_sel == m_vs[1:0], "R3 vec_sel", vec_sel, m_vs);
            check(resume_next == m_rs[0], "R8 resume_next", resume_next, m_rs);
            check(ret_to_wai == m_rt[0], "R5 ret_to_wai", ret_to_wai, m_rt);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enter_wait();
        @(negedge clk) wai_exec = 1'b1;
        @(negedge clk) wai_exec = 1'b0;
    endtask

    initial begin
        step(3);
        rst_ni = 1'b1;
        step(1);
        // R11 reset state
        check(rdy && core_clk_en && !vec_valid && !resume_next && !ret_to_wai && vec_sel == 2'd0,
              "R11 reset outputs", {rdy, core_clk_en, vec_valid, resume_next, ret_to_wai}, 5'b11000);

        // R1 enter wait, R7 unmasked IRQ
        enter_wait();
        check(!rdy && core_clk_en, "R1 waiting", {rdy, core_clk_en}, 2'b01);
        step(3);
        check(!rdy, "R1 still waiting", rdy, 0);
        irq_n = 1'b0;
        step(1);
        check(vec_valid && vec_sel == 2'd3 && rdy, "R7 irq vector", {vec_valid, vec_sel}, 3'b111);
        irq_n = 1'b1;
        step(1);
        check(!vec_valid, "R11 one-cycle pulse", vec_valid, 0);
        check(vec_sel == 2'd3, "R11 vec_sel holds", vec_sel, 3);

        // R8 masked IRQ
        irq_mask = 1'b1;
        enter_wait();
        irq_n = 1'b0;
        step(1);
        check(resume_next && !vec_valid && rdy, "R8 resume", {resume_next, vec_valid}, 2'b10);
        irq_n = 1'b1; irq_mask = 1'b0;
        step(2);

        // R6 NMI edge latched while running
        nmi_n = 1'b0; step(1); nmi_n = 1'b1; step(2);
        enter_wait();
        step(1);
        check(vec_valid && vec_sel == 2'd2, "R6 latched nmi", {vec_valid, vec_sel}, 3'b110);
        // R6 held-low NMI does not re-wake
        enter_wait();
        nmi_n = 1'b0;
        step(1);
        check(vec_valid && vec_sel == 2'd2, "R6 nmi edge wake", {vec_valid, vec_sel}, 3'b110);
        enter_wait();
        step(4);
        check(!rdy && !vec_valid, "R6 held nmi ignored", rdy, 0);
        irq_n = 1'b0; step(1); irq_n = 1'b1; nmi_n = 1'b1;
        step(2);

        // R4 abort stays parked, R5 return flag
        enter_wait();
        abort_n = 1'b0;
        step(1);
        check(vec_valid && vec_sel == 2'd1 && !rdy, "R4 abort vector", {vec_valid, vec_sel, rdy}, 4'b1010);
        step(3);
        check(!vec_valid && !rdy, "R4 held abort quiet", {vec_valid, rdy}, 0);
        abort_n = 1'b1;
        irq_n = 1'b0;
        step(1);
        check(ret_to_wai && vec_valid && vec_sel == 2'd3, "R5 return to wait", ret_to_wai, 1);
        irq_n = 1'b1;
        step(2);
        enter_wait();
        irq_n = 1'b0; step(1);
        check(!ret_to_wai, "R5 no abort no flag", ret_to_wai, 0);
        irq_n = 1'b1; step(2);

        // R3 / R2 all sources together
        enter_wait();
        rst_line_n = 1'b0; abort_n = 1'b0; nmi_n = 1'b0; irq_n = 1'b0;
        step(1);
        check(vec_valid && vec_sel == 2'd0 && rdy, "R2 reset wins", vec_sel, 0);
        rst_line_n = 1'b1; abort_n = 1'b1; nmi_n = 1'b1; irq_n = 1'b1;
        step(2);
        // R3 abort over NMI over IRQ, then the pending NMI
        enter_wait();
        abort_n = 1'b0; nmi_n = 1'b0; irq_n = 1'b0;
        step(1);
        check(vec_valid && vec_sel == 2'd1, "R3 abort over nmi", vec_sel, 1);
        step(1);
        check(vec_valid && vec_sel == 2'd2 && ret_to_wai, "R3 nmi over irq", vec_sel, 2);
        abort_n = 1'b1; nmi_n = 1'b1; irq_n = 1'b1;
        step(2);

        // R9 stop ignores events and a reset line low on entry
        rst_line_n = 1'b0;
        step(1);
        @(negedge clk) stp_exec = 1'b1;
        @(negedge clk) stp_exec = 1'b0;
        check(!core_clk_en && rdy, "R9 clock gated", core_clk_en, 0);
        abort_n = 1'b0; nmi_n = 1'b0; irq_n = 1'b0;
        step(4);
        check(!core_clk_en && !vec_valid, "R9 events ignored", core_clk_en, 0);
        abort_n = 1'b1; nmi_n = 1'b1; irq_n = 1'b1;
        rst_line_n = 1'b1;
        step(2);
        check(!core_clk_en, "R10 rising line no exit", core_clk_en, 0);
        rst_line_n = 1'b0;
        step(1);
        check(core_clk_en && vec_valid && vec_sel == 2'd0, "R10 fall restarts", core_clk_en, 1);
        rst_line_n = 1'b1;
        step(3);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule